// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether the identifier of a received CAN frame may be kept. Each received identifier arrives as four bytes, together with a one-cycle valid strobe. The block compares those bytes against two banks of programmable code and mask bytes. Each bank holds four code/mask byte pairs.

A two-bit mode input splits the same storage in one of four ways:
- two wide filters, each covering all four identifier bytes;
- four half-width filters, each covering the first two identifier bytes;
- eight byte-wide filters, each covering the first identifier byte;
- a shut setting in which nothing passes.

One clock after the strobe, the block raises an accept pulse and reports the number of the filter that matched. That number is a hit index whose numbering depends on the mode.

The receive path upstream supplies the identifier bytes and the strobe. Configuration logic holds the code, mask and mode values steady. The downstream buffer logic uses the accept pulse and the hit index to decide whether to store the frame and how to tag it.

Top module: `id_accept_filter`

## Requirements
- R1: A synchronous active-high reset drives `accept` to 0 and `hit_idx` to 0.
- R2: A mask bit of 1 makes the matching identifier bit irrelevant. A mask bit of 0 requires that identifier bit to equal the code bit. Code and mask byte j sit at bits [8j+7:8j], and identifier byte k sits at bits [8k+7:8k].
- R3: With `mode` = 2'b00 (wide), code/mask bytes 0–3 are compared with identifier bytes 0–3 and give hit 0. Bytes 4–7 are compared with the same identifier bytes and give hit 1.
- R4: With `mode` = 2'b01 (half), four filters are formed: bytes 0–1 give hit 0, bytes 2–3 give hit 1, bytes 4–5 give hit 2, and bytes 6–7 give hit 3. Each filter compares its two bytes with identifier bytes 0–1. Identifier bytes 2–3 have no effect.
- R5: With `mode` = 2'b10 (byte), code/mask byte j is compared with identifier byte 0 and gives hit j, for j = 0 to 7.
- R6: With `mode` = 2'b11 (shut), `accept` never rises, whatever the code, mask and identifier values are.
- R7: When several filters match, `hit_idx` reports the lowest-numbered one.
- R8: `accept` and `hit_idx` are updated on the clock edge that samples `id_valid` high, using the `mode` and the bytes present at that edge. `accept` is 0 in every cycle that does not follow a strobe.
- R9: When no filter matches a strobed identifier, `accept` stays 0 and `hit_idx` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | One-cycle strobe marking a new identifier |
| id_bytes | input | 32 | Identifier bytes 0–3, byte k at [8k+7:8k] |
| code_bytes | input | 64 | Acceptance code bytes 0–7, byte j at [8j+7:8j] |
| mask_bytes | input | 64 | Acceptance mask bytes 0–7, 1 = don't care |
| mode | input | 2 | 00 wide, 01 half, 10 byte, 11 shut |
| accept | output | 1 | Registered acceptance pulse |
| hit_idx | output | 3 | Registered index of the lowest matching filter |

## Verification
Wide mode is tried three ways:
- An identifier that matches only the second bank shows that bank numbering works.
- A single flipped bit in the last identifier byte shows that all four bytes take part in the comparison.
- The same flipped bit with its mask bit set shows that masking works.

Half and byte modes are each fed identifiers whose match lands on one chosen filter away from index 0, which exposes any misnumbered filter. Changing identifier bytes 2–3 in half mode shows that those bytes are ignored. Overlapping matches confirm lowest-index priority.

An all-mask configuration in shut mode, and an unstrobed matching identifier, show that the accept pulse is gated correctly. In both cases the hit index must keep its earlier value.

// File: rtl/idf_pkg.sv
package idf_pkg;

    typedef enum logic [1:0] {
        FM_WIDE32 = 2'b00,
        FM_HALF16 = 2'b01,
        FM_BYTE8  = 2'b10,
        FM_SHUT   = 2'b11
    } fmode_e;

endpackage

// File: rtl/idf_byte_match.sv
module idf_byte_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] id_val,
    input  logic [W-1:0] code_val,
    input  logic [W-1:0] mask_val,
    output logic         hit
);
    // A bit passes when it equals the code bit or when its mask bit is set.
    always_comb begin
        hit = &((~(id_val ^ code_val)) | mask_val);
    end
endmodule

// File: rtl/idf_bank.sv
module idf_bank #(
    parameter int BYTE_W     = 8,
    parameter int BANK_BYTES = 4,
    localparam int HALVES    = BANK_BYTES / 2,
    localparam int VEC_W     = BANK_BYTES * BYTE_W
) (
    input  logic [VEC_W-1:0]      id_vec,
    input  logic [VEC_W-1:0]      code_vec,
    input  logic [VEC_W-1:0]      mask_vec,
    output logic                  m_full,
    output logic [HALVES-1:0]     m_half,
    output logic [BANK_BYTES-1:0] m_byte
);
    logic [BANK_BYTES-1:0] full_b;
    logic [BANK_BYTES-1:0] half_b;

    for (genvar j = 0; j < BANK_BYTES; j++) begin : g_byte
        // Wide mode: code byte j against identifier byte j.
        idf_byte_match #(.W(BYTE_W)) u_full (
            .id_val  (id_vec[j*BYTE_W +: BYTE_W]),
            .code_val(code_vec[j*BYTE_W +: BYTE_W]),
            .mask_val(mask_vec[j*BYTE_W +: BYTE_W]),
            .hit     (full_b[j])
        );

        // Half mode: code byte j against identifier byte (j mod 2).
        idf_byte_match #(.W(BYTE_W)) u_half (
            .id_val  (id_vec[(j % 2)*BYTE_W +: BYTE_W]),
            .code_val(code_vec[j*BYTE_W +: BYTE_W]),
            .mask_val(mask_vec[j*BYTE_W +: BYTE_W]),
            .hit     (half_b[j])
        );

        // Byte mode: code byte j against identifier byte 0.
        idf_byte_match #(.W(BYTE_W)) u_one (
            .id_val  (id_vec[0 +: BYTE_W]),
            .code_val(code_vec[j*BYTE_W +: BYTE_W]),
            .mask_val(mask_vec[j*BYTE_W +: BYTE_W]),
            .hit     (m_byte[j])
        );
    end

    for (genvar k = 0; k < HALVES; k++) begin : g_half
        assign m_half[k] = half_b[2*k] & half_b[2*k+1];
    end

    assign m_full = &full_b;
endmodule

// File: rtl/idf_prio.sv
module idf_prio #(
    parameter int N     = 8,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    // Scan from the top index down so that the lowest match wins.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/id_accept_filter.sv
module id_accept_filter #(
    parameter int BYTE_W     = 8,
    parameter int BANK_BYTES = 4,
    parameter int NUM_BANKS  = 2,
    localparam int HALVES    = BANK_BYTES / 2,
    localparam int NUM_FILT  = NUM_BANKS * BANK_BYTES,
    localparam int IDX_W     = $clog2(NUM_FILT),
    localparam int ID_W      = BANK_BYTES * BYTE_W,
    localparam int CFG_W     = NUM_FILT * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             id_valid,
    input  logic [ID_W-1:0]  id_bytes,
    input  logic [CFG_W-1:0] code_bytes,
    input  logic [CFG_W-1:0] mask_bytes,
    input  logic [1:0]       mode,
    output logic             accept,
    output logic [IDX_W-1:0] hit_idx
);
    import idf_pkg::*;

    typedef struct packed {
        logic             accept;
        logic [IDX_W-1:0] hit;
    } out_s;

    logic [NUM_BANKS-1:0]        full_v;
    logic [NUM_BANKS*HALVES-1:0] half_v;
    logic [NUM_FILT-1:0]         byte_v;
    logic [NUM_FILT-1:0]         hits;
    logic                        any_hit;
    logic [IDX_W-1:0]            first_hit;
    out_s                        st_d, st_q;

    // One comparison bank per group of code/mask bytes.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        idf_bank #(.BYTE_W(BYTE_W), .BANK_BYTES(BANK_BYTES)) u_bank (
            .id_vec  (id_bytes),
            .code_vec(code_bytes[b*ID_W +: ID_W]),
            .mask_vec(mask_bytes[b*ID_W +: ID_W]),
            .m_full  (full_v[b]),
            .m_half  (half_v[b*HALVES +: HALVES]),
            .m_byte  (byte_v[b*BANK_BYTES +: BANK_BYTES])
        );
    end

    // Gather the hit vector that belongs to the selected split.
    always_comb begin
        hits = '0;
        case (fmode_e'(mode))
            FM_WIDE32: hits[NUM_BANKS-1:0]        = full_v;
            FM_HALF16: hits[NUM_BANKS*HALVES-1:0] = half_v;
            FM_BYTE8:  hits                       = byte_v;
            default:   hits                       = '0;
        endcase
    end

    idf_prio #(.N(NUM_FILT)) u_prio (
        .req(hits),
        .any(any_hit),
        .idx(first_hit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.accept = id_valid & any_hit;
        if (id_valid && any_hit) st_d.hit = first_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign accept  = st_q.accept;
    assign hit_idx = st_q.hit;
endmodule

// File: rtl/idf_checker.sv
module idf_checker #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             id_valid,
    input logic [1:0]       mode,
    input logic             accept,
    input logic [IDX_W-1:0] hit_idx
);
    // Becomes 1 only after a reset cycle has been seen, so that no
    // property looks at values from before the first reset.
    logic armed_q = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!accept && hit_idx == '0)); // R1

    AST_SHUT_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (id_valid && mode == 2'b11) |=> !accept); // R6

    AST_NO_STROBE_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !id_valid |=> !accept); // R8

    AST_MISS_HOLDS_INDEX: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !accept |-> hit_idx == $past(hit_idx)); // R9

    AST_WIDE_RANGE: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (id_valid && mode == 2'b00) |=> (!accept || hit_idx <= 1)); // R3

    AST_HALF_RANGE: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (id_valid && mode == 2'b01) |=> (!accept || hit_idx <= 3)); // R4
endmodule

bind id_accept_filter idf_checker #(.IDX_W(IDX_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .id_valid(id_valid),
    .mode    (mode),
    .accept  (accept),
    .hit_idx (hit_idx)
);

// File: tb/id_accept_filter_bench.sv
module id_accept_filter_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        id_valid;
    logic [31:0] id_bytes;
    logic [63:0] code_bytes;
    logic [63:0] mask_bytes;
    logic [1:0]  mode;
    logic        accept;
    logic [2:0]  hit_idx;

    logic [7:0] ib[4];
    logic [7:0] cb[8];
    logic [7:0] mb[8];

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 4; k++) id_bytes[k*8 +: 8] = ib[k];
        for (int j = 0; j < 8; j++) begin
            code_bytes[j*8 +: 8] = cb[j];
            mask_bytes[j*8 +: 8] = mb[j];
        end
    end

    id_accept_filter u_id_accept_filter (
        .clk       (clk),
        .rst       (rst),
        .id_valid  (id_valid),
        .id_bytes  (id_bytes),
        .code_bytes(code_bytes),
        .mask_bytes(mask_bytes),
        .mode      (mode),
        .accept    (accept),
        .hit_idx   (hit_idx)
    );

    task automatic check(string req, logic a_exp, logic [2:0] h_exp);
        n_cmp++;
        if (accept !== a_exp || hit_idx !== h_exp) begin
            n_bad++;
            $display("FAIL %s: accept=%0b hit=%0d expected accept=%0b hit=%0d",
                     req, accept, hit_idx, a_exp, h_exp);
        end
    endtask

    // Strobe one identifier; outputs are sampled at the following negedge.
    task automatic strobe(logic [1:0] m);
        @(negedge clk);
        mode     = m;
        id_valid = 1'b1;
        @(negedge clk);
        id_valid = 1'b0;
    endtask

    task automatic clear_cfg();
        for (int j = 0; j < 8; j++) begin
            cb[j] = 8'hA0 + 8'(j);
            mb[j] = 8'h00;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; id_valid = 1'b0; mode = 2'b00;
        for (int k = 0; k < 4; k++) ib[k] = 8'h00;
        clear_cfg();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", 1'b0, 3'd0);
    endtask

    task automatic t_wide();
        clear_cfg();
        ib[0] = 8'h12; ib[1] = 8'h34; ib[2] = 8'h56; ib[3] = 8'h78;
        cb[4] = 8'h12; cb[5] = 8'h34; cb[6] = 8'h56; cb[7] = 8'h78;
        strobe(2'b00);
        check("R3 bank1 gives hit 1", 1'b1, 3'd1);
        @(negedge clk);
        check("R8 single pulse", 1'b0, 3'd1);
        ib[3] = 8'h79;
        strobe(2'b00);
        check("R9 miss holds index", 1'b0, 3'd1);
        mb[7] = 8'h01;
        strobe(2'b00);
        check("R2 masked bit ignored", 1'b1, 3'd1);
        cb[0] = 8'h12; cb[1] = 8'h34; cb[2] = 8'h56; cb[3] = 8'h79;
        strobe(2'b00);
        check("R7 both banks lowest wins", 1'b1, 3'd0);
    endtask

    task automatic t_half();
        clear_cfg();
        ib[0] = 8'h5A; ib[1] = 8'hC3; ib[2] = 8'h11; ib[3] = 8'h22;
        cb[6] = 8'h5A; cb[7] = 8'hC3;
        strobe(2'b01);
        check("R4 bytes 6-7 give hit 3", 1'b1, 3'd3);
        ib[2] = 8'hEE; ib[3] = 8'h99;
        strobe(2'b01);
        check("R4 identifier bytes 2-3 ignored", 1'b1, 3'd3);
        cb[2] = 8'h5A; cb[3] = 8'hC2; mb[3] = 8'h01;
        strobe(2'b01);
        check("R2 R4 bytes 2-3 masked give hit 1", 1'b1, 3'd1);
    endtask

    task automatic t_byte();
        clear_cfg();
        ib[0] = 8'hA5; ib[1] = 8'h00; ib[2] = 8'h00; ib[3] = 8'h00;
        strobe(2'b10);
        check("R5 byte 5 vs identifier byte 0", 1'b1, 3'd5);
        cb[2] = 8'hA5;
        strobe(2'b10);
        check("R7 byte mode lowest wins", 1'b1, 3'd2);
        clear_cfg();
        cb[7] = 8'h00; mb[7] = 8'hFF;
        ib[0] = 8'h3C;
        strobe(2'b10);
        check("R5 byte 7 all masked", 1'b1, 3'd7);
    endtask

    task automatic t_shut();
        for (int j = 0; j < 8; j++) mb[j] = 8'hFF;
        strobe(2'b11);
        check("R6 shut mode never accepts", 1'b0, 3'd7);
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        mode = 2'b00;
        @(negedge clk);
        check("R8 no strobe no accept", 1'b0, 3'd7);
        strobe(2'b00);
        check("R8 strobe with open masks", 1'b1, 3'd0);
    endtask

    initial begin
        t_reset();
        t_wide();
        t_half();
        t_byte();
        t_shut();
        t_no_strobe();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule